// File: doc/BRIEF.md
# Clocked Controller for a 64K x 16 Asynchronous Static RAM

This block lets a synchronous host read and write an asynchronous static RAM of 65,536 sixteen-bit words. Each access can cover the lower byte, the upper byte or the whole word. The host offers a request along with an address, a write flag, two byte enables and write data. The controller accepts the request only while its ready output is high. A read returns its data with a one-cycle valid strobe.

On the memory side the controller drives five active-low strobes: chip select, output enable, write enable and two lane selects. It also drives the 16-bit address. The bidirectional data bus is split into an output word, an input word and a drive enable.

Every strobe sequence is built from the memory's minimum timings, which are given in nanoseconds. Each one is turned into a whole number of clock cycles by ceiling division with the clock period.

A write can follow a read. In that case the controller waits out the memory's output-disable time before it places data on the bus, so the two sides never drive the bus together. The request fields are captured when the request is accepted, and they stay frozen for the whole access.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, the following hold: `host_rdy` is 1, the five memory strobes (`mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n`, `mem_ub_n`) are all 1, `mem_drv` is 0 and `host_rvalid` is 0.
- R2: A read drives `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. Byte enable bit 0 selects the lower lane (data bits 7:0, `mem_lb_n`=0). Bit 1 selects the upper lane (bits 15:8, `mem_ub_n`=0). The strobes are held for RD_CYC = max(ceil(tRC/T), ceil(tAA/T)) cycles, which is 18 at 70 ns and T=4 ns. `host_rvalid` rises on the clock edge that comes RD_CYC edges after the accepting edge. At that point `host_rdata` holds the memory data sampled in the last strobe cycle.
- R3: A write updates only the lanes whose byte enable is 1, and the other lane keeps its content.
- R4: A write first spends one cycle with `mem_cs_n`=0 and `mem_we_n`=1. It then holds `mem_we_n` low for at least ceil(tWP/T) cycles, which is 14. The data must be driven for at least ceil(tDW/T) cycles, which is 8, before `mem_we_n` rises.
- R5: `mem_drv` is 1 only while `mem_cs_n`=0 and `mem_oe_n`=1. It is still 1 in the cycle after `mem_we_n` rises, and it falls on the next edge.
- R6: `mem_drv` never rises fewer than TA_CYC = ceil(tHZ/T) cycles after `mem_oe_n` rises, which is 7 cycles.
- R7: After an accepted request, `host_rdy` stays 0 for the full minimum cycle. It returns to 1 eighteen edges after the accepting edge for both reads and writes at the default timings.
- R8: While `mem_cs_n` stays low, the address, the lane selects and the driven write data do not change.
- R9: `host_rvalid` is never high for two cycles in a row.
- R10: When both byte enables are 0, a write leaves the word unchanged, and a read returns 16'h0000.
- R11: `mem_oe_n` and `mem_we_n` are never both low.
- R12: A lane that was not selected in a read returns 8'h00 in `host_rdata`, whatever is present on `mem_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request strobe |
| host_rdy | output | 1 | Controller idle, so a request is accepted |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Data toward memory |
| mem_din | input | 16 | Data from memory |
| mem_drv | output | 1 | Data bus drive enable |

## Verification
A read's valid strobe and data are due exactly RD_CYC edges after the accepting edge. Ready returns on that same edge for a read, and eighteen edges after acceptance for a write. The bench counts falling edges from the accepting edge and compares both results against those fixed counts, not against whenever they happen to appear.

The memory model samples its strobes on falling edges. It commits a write when write enable is seen high again, so each read-back check also covers the lane masking of the write before it.

Running monitors measure the write-enable low run, the driven-data window before its end, and the gap between output enable rising and drive starting. Each of these is checked at the falling edge where the relevant transition first becomes visible.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    // ceiling conversion of a nanosecond figure to clock cycles
    function automatic int ns2cyc(input int ns, input int period_ns);
        if (ns <= 0) return 0;
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WSET,
        PH_WPULSE,
        PH_WREC
    } phase_e;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } hreq_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic sel;
    } strobe_t;

    function automatic strobe_t strobes_of(input phase_e ph);
        strobe_t s;
        s = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, sel: 1'b0};
        case (ph)
            PH_READ:   s = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, sel: 1'b1};
            PH_WSET:   s = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, sel: 1'b1};
            PH_WPULSE: s = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, sel: 1'b1};
            PH_WREC:   s = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, sel: 1'b1};
            default:   s = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, sel: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      active,
    input  logic [LANES-1:0]          be,
    input  logic [LANES*LANE_W-1:0]   din,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES-1:0]          bs_n,
    output logic [LANES*LANE_W-1:0]   rmask,
    output logic [LANES*LANE_W-1:0]   dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bs_n[g] = ~(active & be[g]);
        assign rmask[g*LANE_W +: LANE_W] = be[g] ? din[g*LANE_W +: LANE_W] : '0;
        assign dout[g*LANE_W +: LANE_W]  = wdata[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   req_wr,
    input  logic   ph_done,
    input  logic   dw_done,
    output phase_e ph,
    output phase_e ph_nx,
    output logic   accept
);
    assign accept = (ph == PH_IDLE) && req;

    always_comb begin
        ph_nx = ph;
        case (ph)
            PH_IDLE:   if (req) ph_nx = req_wr ? PH_WSET : PH_READ;
            PH_READ:   if (ph_done) ph_nx = PH_IDLE;
            PH_WSET:   if (ph_done) ph_nx = PH_WPULSE;
            PH_WPULSE: if (ph_done && dw_done) ph_nx = PH_WREC;
            PH_WREC:   if (ph_done) ph_nx = PH_IDLE;
            default:   ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_IDLE;
        else     ph <= ph_nx;
    end
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 55,
    parameter int T_CW_NS = 65,
    parameter int T_AW_NS = 65,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    output logic              host_rdy,
    input  logic              host_wr,
    input  logic [LANES-1:0]  host_be,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_drv
);
    localparam int RD_CYC    = imax(1, imax(ns2cyc(T_RC_NS, CLK_PERIOD_NS), ns2cyc(T_AA_NS, CLK_PERIOD_NS)));
    localparam int SET_CYC   = 1;
    localparam int PULSE_CYC = imax(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                    imax(ns2cyc(T_CW_NS, CLK_PERIOD_NS), ns2cyc(T_AW_NS, CLK_PERIOD_NS)) - SET_CYC);
    localparam int WP_CYC    = imax(1, PULSE_CYC);
    localparam int DW_CYC    = imax(1, ns2cyc(T_DW_NS, CLK_PERIOD_NS));
    localparam int TA_CYC    = imax(1, ns2cyc(T_HZ_NS, CLK_PERIOD_NS));
    localparam int REC_CYC   = imax(1, ns2cyc(T_WC_NS, CLK_PERIOD_NS) - SET_CYC - WP_CYC);
    localparam int MAXC      = imax(imax(RD_CYC, WP_CYC), imax(imax(TA_CYC, DW_CYC), REC_CYC));
    localparam int CNT_W     = $clog2(MAXC + 1);

    phase_e         ph, ph_nx;
    logic           accept;
    logic           ph_done, dw_done, ta_done;
    logic           ph_load, ta_load;
    logic [CNT_W-1:0] ph_val;
    hreq_t          cur_q;
    strobe_t        stb_q;
    logic           drv_q, rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [LANES-1:0]  bs_n;
    logic [DATA_W-1:0] rmask;

    sramc_seq u_seq (
        .clk(clk), .rst(rst), .req(host_req), .req_wr(host_wr),
        .ph_done(ph_done), .dw_done(dw_done),
        .ph(ph), .ph_nx(ph_nx), .accept(accept)
    );

    assign ph_load = (ph_nx != ph);
    assign ta_load = (ph == PH_READ) && (ph_nx != PH_READ);

    always_comb begin
        case (ph_nx)
            PH_READ:   ph_val = CNT_W'(RD_CYC - 1);
            PH_WSET:   ph_val = CNT_W'(SET_CYC - 1);
            PH_WPULSE: ph_val = CNT_W'(WP_CYC - 1);
            PH_WREC:   ph_val = CNT_W'(REC_CYC - 1);
            default:   ph_val = '0;
        endcase
    end

    // phase length counter
    sramc_timer #(.W(CNT_W)) u_ph_tmr (
        .clk(clk), .rst(rst), .load(ph_load), .en(1'b1),
        .load_val(ph_val), .done(ph_done)
    );

    // output-disable turnaround after a read
    sramc_timer #(.W(CNT_W)) u_ta_tmr (
        .clk(clk), .rst(rst), .load(ta_load), .en(1'b1),
        .load_val(CNT_W'(TA_CYC)), .done(ta_done)
    );

    // counts driven cycles so data meets its setup before write end
    sramc_timer #(.W(CNT_W)) u_dw_tmr (
        .clk(clk), .rst(rst), .load(accept), .en(drv_q),
        .load_val(CNT_W'(DW_CYC)), .done(dw_done)
    );

    sramc_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .active(stb_q.sel), .be(cur_q.be), .din(mem_din), .wdata(cur_q.wdata),
        .bs_n(bs_n), .rmask(rmask), .dout(mem_dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            stb_q    <= strobes_of(PH_IDLE);
            drv_q    <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (accept)
                cur_q <= '{be: host_be, addr: host_addr, wdata: host_wdata};
            stb_q    <= strobes_of(ph_nx);
            drv_q    <= (ph == PH_WPULSE) && (ta_done || drv_q);
            rvalid_q <= (ph == PH_READ) && ph_done;
            if ((ph == PH_READ) && ph_done)
                rdata_q <= rmask;
        end
    end

    assign host_rdy    = (ph == PH_IDLE);
    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;
    assign mem_cs_n    = stb_q.cs_n;
    assign mem_oe_n    = stb_q.oe_n;
    assign mem_we_n    = stb_q.we_n;
    assign mem_lb_n    = bs_n[0];
    assign mem_ub_n    = bs_n[1];
    assign mem_addr    = cur_q.addr;
    assign mem_drv     = drv_q;
endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int TA_CYC = 7
) (
    input logic        clk,
    input logic        rst,
    input logic        host_rdy,
    input logic        host_rvalid,
    input logic        mem_cs_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic        mem_lb_n,
    input logic        mem_ub_n,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_dout,
    input logic        mem_drv
);
    localparam int GW = $clog2(TA_CYC + 1) + 1;
    logic [GW-1:0] oe_gap;

    always_ff @(posedge clk) begin
        if (rst)
            oe_gap <= GW'(TA_CYC);
        else if (!mem_oe_n)
            oe_gap <= '0;
        else if (oe_gap < GW'(TA_CYC))
            oe_gap <= oe_gap + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        host_rdy |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_drv));

    // R5
    drv_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_drv |-> (!mem_cs_n && mem_oe_n));

    // R5
    drv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !mem_cs_n) |-> mem_drv);

    // R4
    we_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_drv) |-> (oe_gap >= GW'(TA_CYC)));

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    // R8
    wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_drv && $past(mem_drv)) |-> $stable(mem_dout));

    // R9
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);

    // R11
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);
endmodule

bind sramc_ctrl sramc_chk #(.TA_CYC(TA_CYC)) chk_i (
    .clk(clk), .rst(rst), .host_rdy(host_rdy), .host_rvalid(host_rvalid),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_drv(mem_drv)
);

// File: tb/sramc_ctrl_tb_top.sv
module sramc_ctrl_tb_top;
    localparam int T_NS   = 4;
    localparam int RD_C   = 18;   // ceil(70/4)
    localparam int WC_C   = 18;   // ceil(70/4)
    localparam int WP_MIN = 14;   // ceil(55/4)
    localparam int DW_MIN = 8;    // ceil(30/4)
    localparam int TA_MIN = 7;    // ceil(25/4)

    typedef struct packed {
        logic        wr;
        logic [1:0]  be;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b11, 16'h0010, 16'hBEEF, 16'h0000},
        '{1'b0, 2'b11, 16'h0010, 16'h0000, 16'hBEEF},
        '{1'b1, 2'b01, 16'h0010, 16'h3412, 16'h0000},
        '{1'b0, 2'b11, 16'h0010, 16'h0000, 16'hBE12},
        '{1'b1, 2'b10, 16'h0010, 16'h5A77, 16'h0000},
        '{1'b0, 2'b11, 16'h0010, 16'h0000, 16'h5A12},
        '{1'b0, 2'b01, 16'h0010, 16'h0000, 16'h0012},
        '{1'b0, 2'b10, 16'h0010, 16'h0000, 16'h5A00},
        '{1'b1, 2'b00, 16'h0010, 16'hFFFF, 16'h0000},
        '{1'b0, 2'b11, 16'h0010, 16'h0000, 16'h5A12},
        '{1'b1, 2'b11, 16'hFFFF, 16'h1234, 16'h0000},
        '{1'b0, 2'b11, 16'hFFFF, 16'h0000, 16'h1234},
        '{1'b0, 2'b00, 16'hFFFF, 16'h0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_rdy;
    logic        host_wr = 1'b0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_drv;
    logic [15:0] mem_addr, mem_dout, mem_din;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(T_NS/2) clk = ~clk;

    sramc_ctrl #(.CLK_PERIOD_NS(T_NS)) dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_rdy(host_rdy),
        .host_wr(host_wr), .host_be(host_be), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_drv(mem_drv)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // small memory model: 256 words, undriven lanes show 8'hEE
    logic [15:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = '0;

    always_comb begin
        mem_din[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? mem[mem_addr[7:0]][7:0]  : 8'hEE;
        mem_din[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? mem[mem_addr[7:0]][15:8] : 8'hEE;
    end

    // monitors at falling edges
    logic prev_we = 1'b1;
    logic prev_drv = 1'b0;
    int   we_run = 0;
    int   drv_run = 0;
    int   since_oe = 100;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_oe_n) since_oe = 0;
            else if (since_oe < 100) since_oe++;
            if (mem_drv && !prev_drv)
                chk(since_oe - 1 >= TA_MIN, "R6 drive-after-oe gap", since_oe - 1, TA_MIN);
            if (!mem_we_n) begin
                we_run++;
                if (mem_drv) drv_run++;
            end
            if (mem_we_n && !prev_we && !mem_cs_n) begin
                chk(we_run >= WP_MIN, "R4 write pulse length", we_run, WP_MIN);
                chk(drv_run >= DW_MIN, "R4 data before write end", drv_run, DW_MIN);
                chk(mem_drv, "R5 drive held after we rise", mem_drv, 1);
                if (mem_drv) begin
                    if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dout[7:0];
                    if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dout[15:8];
                end
                we_run = 0;
                drv_run = 0;
            end
            prev_we = mem_we_n;
            prev_drv = mem_drv;
        end
    end

    task automatic run_op(input vec_t v);
        int cnt;
        @(negedge clk);
        host_req = 1'b1; host_wr = v.wr; host_be = v.be;
        host_addr = v.addr; host_wdata = v.wdata;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        cnt = 1;
        if (v.wr) begin
            chk(!mem_cs_n && mem_oe_n && mem_we_n, "R4 setup cycle strobes",
                {mem_cs_n, mem_oe_n, mem_we_n}, 3'b011);
            while (!host_rdy && cnt < 200) begin @(negedge clk); cnt++; end
            chk(cnt == WC_C + 1, "R7 write ready latency", cnt, WC_C + 1);
        end else begin
            chk({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == {3'b001, ~v.be},
                "R2 read strobes", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n},
                {3'b001, ~v.be});
            while (!host_rvalid && cnt < 200) begin @(negedge clk); cnt++; end
            chk(cnt == RD_C + 1, "R2 rvalid latency", cnt, RD_C + 1);
            chk(host_rdy, "R7 ready with read data", host_rdy, 1);
            // R3 R10 R12: lane masking of read data and of prior writes
            chk(host_rdata == v.exp, "R3/R10/R12 read data", host_rdata, v.exp);
            @(negedge clk);
            chk(!host_rvalid, "R9 rvalid single cycle", host_rvalid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_rdy && mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_drv && !host_rvalid,
            "R1 reset outputs",
            {host_rdy, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_drv, host_rvalid}, 8'b11111100);
        rst = 1'b0;
        @(negedge clk);
        chk(host_rdy && mem_cs_n && !mem_drv, "R1 idle after reset",
            {host_rdy, mem_cs_n, mem_drv}, 3'b110);

        for (int i = 0; i < NV; i++) run_op(VEC[i]);

        // R10 both-lane-disabled write leaves word intact
        chk(mem[8'h10] == 16'h5A12, "R10 no-lane write kept word", mem[8'h10], 16'h5A12);
        // R3 upper-lane write left lower lane of top address untouched
        run_op('{1'b1, 2'b10, 16'hFFFF, 16'hC3C3, 16'h0000});
        chk(mem[8'hFF] == 16'hC334, "R3 lower lane kept", mem[8'hFF], 16'hC334);
        // R11 idle strobes after the sequence
        @(negedge clk);
        chk(mem_oe_n && mem_we_n && host_rdy, "R11 idle strobes", {mem_oe_n, mem_we_n, host_rdy}, 3'b111);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule